// File: doc/BRIEF.md
# Priority-Ordered Branching State Machine

This block is a small clocked controller with one home state and three branch states. While at home it samples three single-bit qualifiers, `x_i`, `y_i` and `z_i`, and picks at most one branch for the next cycle. The conditions overlap, so they are checked in a fixed order of precedence. As a result, each of the eight input combinations leads to exactly one successor.

A branch state lasts exactly one cycle. The machine then goes home on the next rising edge, whatever the inputs are. The current state is given as a two-bit code. A one-hot vector gives the same information, so downstream logic can use a single bit per state. All pins are plain control and status signals, with no handshake. Reset is synchronous and active high.

Top module: `prio_fsm`

## Requirements
- R1: While `rst` is high at a rising edge, the state after that edge is home (code 00), whatever the qualifiers are.
- R2: At home, with `x_i` and `y_i` both high, the next state is branch one (code 01).
- R3: At home, with `x_i` and `z_i` high and `y_i` low, the next state is branch two (code 10).
- R4: At home, with `x_i` high and both `y_i` and `z_i` low, the next state is branch three (code 11).
- R5: At home, with `x_i` low, the machine stays at home whatever `y_i` and `z_i` are.
- R6: At home, with all three qualifiers high, the first-ranked condition wins and the next state is branch one (code 01).
- R7: From any branch state (codes 01, 10, 11), the next state is home, whatever the qualifiers are.
- R8: `state_o` carries the state code. `onehot_o` has exactly one bit set, and that bit's index equals the state code (bit 0 = home, bit 1 = branch one, bit 2 = branch two, bit 3 = branch three).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| x_i | input | 1 | Primary qualifier; no branch is taken while it is low |
| y_i | input | 1 | Qualifier for branch one (highest rank) |
| z_i | input | 1 | Qualifier for branch two (second rank) |
| state_o | output | 2 | Current state code: 00 home, 01/10/11 branches one to three |
| onehot_o | output | 4 | One-hot copy of the state, indexed by state code |

## Verification
The hardest case to produce is reset taking effect while the machine sits in a branch state with the qualifiers still asking for a new branch. The machine stays in a branch state for only one cycle. To reach this case, the stimulus steers into branch three, holds all qualifiers high and raises reset in that same cycle. It then checks that home wins over both the return path and the branch request. Overlap between conditions is covered by sweeping all eight qualifier combinations at home and comparing each result with a rank-ordered model in the bench.

// File: rtl/prio_fsm_pkg.sv
package prio_fsm_pkg;
  localparam int STATE_W = 2;
  localparam int NUM_ST  = 1 << STATE_W;

  typedef enum logic [STATE_W-1:0] {
    ST_HOME = 2'b00,
    ST_BR1  = 2'b01,
    ST_BR2  = 2'b10,
    ST_BR3  = 2'b11
  } st_e;
endpackage

// File: rtl/prio_fsm_next.sv
module prio_fsm_next
  import prio_fsm_pkg::*;
(
  input  st_e  cur_st,
  input  logic x_i,
  input  logic y_i,
  input  logic z_i,
  output st_e  nxt_st
);
  always_comb begin
    nxt_st = ST_HOME;
    case (cur_st)
      ST_HOME: begin
        // rank order: first matching pattern wins
        casez ({x_i, y_i, z_i})
          3'b11?:  nxt_st = ST_BR1;
          3'b1?1:  nxt_st = ST_BR2;
          3'b1??:  nxt_st = ST_BR3;
          default: nxt_st = ST_HOME;
        endcase
      end
      ST_BR1, ST_BR2, ST_BR3: nxt_st = ST_HOME;
      default: nxt_st = ST_HOME;
    endcase
  end
endmodule

// File: rtl/prio_fsm_decode.sv
module prio_fsm_decode
  import prio_fsm_pkg::*;
(
  input  logic [STATE_W-1:0] code_i,
  output logic [NUM_ST-1:0]  hot_o
);
  for (genvar g = 0; g < NUM_ST; g++) begin : g_hot
    assign hot_o[g] = (code_i == STATE_W'(g));
  end
endmodule

// File: rtl/prio_fsm.sv
module prio_fsm
  import prio_fsm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       x_i,
  input  logic       y_i,
  input  logic       z_i,
  output logic [1:0] state_o,
  output logic [3:0] onehot_o
);
  st_e cur_st;
  st_e nxt_st;

  prio_fsm_next u_next (
    .cur_st (cur_st),
    .x_i    (x_i),
    .y_i    (y_i),
    .z_i    (z_i),
    .nxt_st (nxt_st)
  );

  always_ff @(posedge clk) begin
    if (rst) cur_st <= ST_HOME;
    else     cur_st <= nxt_st;
  end

  assign state_o = cur_st;

  prio_fsm_decode u_dec (
    .code_i (state_o),
    .hot_o  (onehot_o)
  );
endmodule

// File: rtl/prio_fsm_chk.sv
module prio_fsm_chk (
  input logic       clk,
  input logic       rst,
  input logic       x_i,
  input logic       y_i,
  input logic       z_i,
  input logic [1:0] state_o,
  input logic [3:0] onehot_o
);
  p_reset_home_r1: assert property (@(posedge clk)
    rst |=> state_o == 2'b00);

  p_branch_one_r2: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b00 && x_i && y_i) |=> state_o == 2'b01);

  p_branch_two_r3: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b00 && x_i && !y_i && z_i) |=> state_o == 2'b10);

  p_branch_three_r4: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b00 && x_i && !y_i && !z_i) |=> state_o == 2'b11);

  p_hold_home_r5: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b00 && !x_i) |=> state_o == 2'b00);

  p_all_high_r6: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b00 && x_i && y_i && z_i) |=> state_o == 2'b01);

  p_return_home_r7: assert property (@(posedge clk) disable iff (rst)
    (state_o != 2'b00) |=> state_o == 2'b00);

  p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(onehot_o) == 1 && onehot_o[state_o]);
endmodule

bind prio_fsm prio_fsm_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .x_i      (x_i),
  .y_i      (y_i),
  .z_i      (z_i),
  .state_o  (state_o),
  .onehot_o (onehot_o)
);

// File: tb/prio_fsm_tb.sv
module prio_fsm_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       x_i = 1'b0, y_i = 1'b0, z_i = 1'b0;
  logic [1:0] state_o;
  logic [3:0] onehot_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prio_fsm u_dut (
    .clk(clk), .rst(rst), .x_i(x_i), .y_i(y_i), .z_i(z_i),
    .state_o(state_o), .onehot_o(onehot_o)
  );

  function automatic logic [1:0] model(input logic [2:0] xyz);
    if (!xyz[2])     return 2'b00;
    else if (xyz[1]) return 2'b01;
    else if (xyz[0]) return 2'b10;
    else             return 2'b11;
  endfunction

  task automatic chk(input string req, input logic [1:0] exp_st);
    logic [3:0] exp_oh;
    exp_oh = 4'b0001 << exp_st;
    checks++;
    if (state_o !== exp_st) begin
      errors++;
      $display("FAIL %s state actual=%b expected=%b", req, state_o, exp_st);
    end
    checks++;
    if (onehot_o !== exp_oh) begin
      errors++;
      $display("FAIL R8 onehot actual=%b expected=%b", onehot_o, exp_oh);
    end
  endtask

  function automatic string req_of(input logic [2:0] xyz);
    if (!xyz[2])       return "R5";
    if (xyz == 3'b111) return "R6";
    if (xyz[1])        return "R2";
    if (xyz[0])        return "R3";
    return "R4";
  endfunction

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", 2'b00);
    rst = 1'b0;
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      {x_i, y_i, z_i} = 3'(v);
      @(negedge clk);
      chk(req_of(3'(v)), model(3'(v)));
      // qualifiers now demand a branch; branch states must still go home
      {x_i, y_i, z_i} = 3'b111;
      @(negedge clk);
      if (model(3'(v)) != 2'b00) chk("R7", 2'b00);
      else                        chk("R6", 2'b01);
      {x_i, y_i, z_i} = 3'b000;
      @(negedge clk);
      chk("R7", 2'b00);
    end
    // reset while in a branch state with a branch request present
    {x_i, y_i, z_i} = 3'b100;
    @(negedge clk);
    chk("R4", 2'b11);
    {x_i, y_i, z_i} = 3'b111;
    rst = 1'b1;
    @(negedge clk);
    chk("R1", 2'b00);
    @(negedge clk);
    chk("R1", 2'b00);
    rst = 1'b0;
    @(negedge clk);
    chk("R6", 2'b01);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule